// File: doc/BRIEF.md
# Management-Bus PHY Register Responder

This block stands in for one Ethernet PHY sitting behind a host-side management command interface. The host has four word-wide registers: a control word, a command word, a write-data word and a read-data word. To reach the PHY, the host first loads the write-data word when a write is needed. It then writes a command word that names a PHY address, a register number and an opcode, with the initiate flag set. The access completes in the same clock edge that accepts the command. The host never has to poll, because the command word always reads back as ready.

One emulated PHY answers at the address set by a parameter. It holds thirty-two 16-bit registers. Most of them are plain storage. Four register numbers return values derived from the link flag and from the host's advertisement register (number 4): basic status, partner ability, a fixed speed indication and a diagnostic word. A read aimed at any other PHY address returns all ones, and a write aimed at one is dropped. The serial bit timing of the management wires is not modelled.

Top module: `mgmt_phy_top`

## Requirements
- R1: A command write whose initiate flag (bit 11) is set and whose opcode (bits 15:14) is 2 loads the read-data word with the PHY register value zero-extended to 32 bits. The PHY address comes from bits 28:24 and the register number from bits 20:16. The new value is visible after that clock edge.
- R2: A command with initiate set and opcode 1, aimed at the configured PHY address, stores bits 15:0 of the write-data word into the selected register. A later read returns that value.
- R3: A command with initiate set and opcode 0 or 3 leaves PHY storage and the read-data word unchanged. It raises `bad_op` for the one cycle after the edge that accepted it.
- R4: A command written with initiate clear performs no PHY access, and the read-data word keeps its value.
- R5: Reading the command word returns the last value written, with bit 7 forced to 1.
- R6: A read aimed at any PHY address other than the configured one returns 0x0000FFFF. A write aimed at such an address changes no register of the configured PHY.
- R7: Register 1 reads 0x782E while `link_up` is high and 0x0000 while it is low, whatever was written to it.
- R8: Register 5 reads 0x4000 OR (register 4 AND 0x01E0) OR 0x0001.
- R9: Register 17 always reads 0x8000. Register 18 reads 0 while the link is down. While the link is up, bit 10 of register 18 is register 4 bit 7 OR bit 8, and bit 11 is register 4 bit 8 OR bit 6.
- R10: After reset, registers 0, 2, 3 and 4 hold 0x3100, 0x0300, 0xE400 and 0x01E1, and every other stored register holds 0.
- R11: Host register select codes are control=0, command=1, write-data=2, read-data=3. The control word keeps only bits 6:0 and reads zero above them. The write-data and read-data words store and return all 32 bits. All host words reset to 0 (the command word therefore reads 0x00000080).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link flag that feeds the derived status registers |
| host_we | input | 1 | Host write strobe |
| host_wsel | input | 2 | Host register selected for the write |
| host_wdata | input | 32 | Host write value |
| host_rsel | input | 2 | Host register selected for the read |
| host_rdata | output | 32 | Host read value (combinational from `host_rsel`) |
| bad_op | output | 1 | One-cycle flag for an initiated command with an invalid opcode |

## Verification
Several properties are checked on every cycle. The read-data word stays put unless an initiated command or a direct write reaches it, and an invalid opcode leaves it untouched. A read aimed at an absent PHY address yields all ones. Register 17 always reads its fixed value. The control word never shows bits above 6, and the command word always reads as ready. Other behaviour depends on history and needs the bench's scenarios to show it. These are the exact reset contents, the derived status words as the link flag and advertisement change, writes that land or are discarded according to the address, and the way stored and computed register numbers interact. A reference model of the register file checks them in mixed directed and random command sequences.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

    localparam int REG_AW   = 5;
    localparam int NREG     = 1 << REG_AW;
    localparam int WORD_W   = 16;
    localparam int HOST_W   = 32;

    // Command word field positions (host software decodes these)
    localparam int CMD_PHY_LSB   = 24;
    localparam int CMD_REG_LSB   = 16;
    localparam int CMD_OP_LSB    = 14;
    localparam int CMD_GO_BIT    = 11;
    localparam int CMD_READY_BIT = 7;

    typedef enum logic [1:0] {
        HSEL_CTRL  = 2'd0,
        HSEL_CMD   = 2'd1,
        HSEL_WDATA = 2'd2,
        HSEL_RDATA = 2'd3
    } host_sel_e;

    typedef enum logic [1:0] {
        OP_RSV0  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RSV3  = 2'd3
    } mgmt_op_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              bad;
        logic              hit;
        logic [REG_AW-1:0] idx;
    } phy_access_t;

    function automatic logic [WORD_W-1:0] reset_word(input int unsigned i);
        case (i)
            0:       return 16'h3100;
            2:       return 16'h0300;
            3:       return 16'hE400;
            4:       return 16'h01E1;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] link_status_word(input logic up);
        return up ? 16'h782E : 16'h0000;
    endfunction

    function automatic logic [WORD_W-1:0] partner_word(input logic [WORD_W-1:0] adv);
        return 16'h4000 | (adv & 16'h01E0) | 16'h0001;
    endfunction

    function automatic logic [WORD_W-1:0] diag_word(input logic up,
                                                    input logic [WORD_W-1:0] adv);
        logic dup;
        logic spd;
        dup = adv[8] | adv[6];
        spd = adv[7] | adv[8];
        return up ? {4'b0000, dup, spd, 10'b0} : 16'h0000;
    endfunction

endpackage

// File: rtl/mgmt_cmd_decode.sv
module mgmt_cmd_decode
    import mgmt_phy_pkg::*;
#(
    parameter int PHY_ADDR = 7
) (
    input  logic              cmd_we,
    input  logic [REG_AW-1:0] phy_sel,
    input  logic [REG_AW-1:0] reg_sel,
    input  logic [1:0]        op_code,
    input  logic              go,
    output phy_access_t       acc
);

    localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(PHY_ADDR);

    logic     start;
    mgmt_op_e op;

    always_comb begin
        op      = mgmt_op_e'(op_code);
        start   = cmd_we && go;
        acc.hit = (phy_sel == MY_ADDR);
        acc.idx = reg_sel;
        acc.wr  = start && (op == OP_WRITE) && acc.hit;
        acc.rd  = start && (op == OP_READ);
        acc.bad = start && (op == OP_RSV0 || op == OP_RSV3);
    end

endmodule

// File: rtl/phy_word_store.sv
module phy_word_store
    import mgmt_phy_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [REG_AW-1:0]            widx,
    input  logic [WORD_W-1:0]            wval,
    output logic [NREG-1:0][WORD_W-1:0]  words
);

    for (genvar g = 0; g < NREG; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= reset_word(g);
            end else if (we && widx == REG_AW'(g)) begin
                words[g] <= wval;
            end
        end
    end

endmodule

// File: rtl/phy_status_view.sv
module phy_status_view
    import mgmt_phy_pkg::*;
(
    input  logic                         link_up,
    input  logic [REG_AW-1:0]            ridx,
    input  logic [NREG-1:0][WORD_W-1:0]  words,
    output logic [WORD_W-1:0]            rval
);

    always_comb begin
        case (ridx)
            5'd1:    rval = link_status_word(link_up);
            5'd5:    rval = partner_word(words[4]);
            5'd17:   rval = 16'h8000;
            5'd18:   rval = diag_word(link_up, words[4]);
            default: rval = words[ridx];
        endcase
    end

endmodule

// File: rtl/mgmt_phy_top.sv
module mgmt_phy_top
    import mgmt_phy_pkg::*;
#(
    parameter int PHY_ADDR  = 7,
    parameter int CTRL_BITS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up,
    input  logic              host_we,
    input  logic [1:0]        host_wsel,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic [1:0]        host_rsel,
    output logic [HOST_W-1:0] host_rdata,
    output logic              bad_op
);

    localparam logic [WORD_W-1:0] ABSENT_WORD = '1;

    logic [CTRL_BITS-1:0]            ctrl_q;
    logic [HOST_W-1:0]               cmd_q;
    logic [HOST_W-1:0]               wdata_q;
    logic [HOST_W-1:0]               rdata_q;
    logic                            bad_op_q;
    phy_access_t                     acc;
    logic [NREG-1:0][WORD_W-1:0]     words;
    logic [WORD_W-1:0]               view_val;
    logic                            cmd_we;

    assign cmd_we = host_we && (host_sel_e'(host_wsel) == HSEL_CMD);

    mgmt_cmd_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
        .cmd_we  (cmd_we),
        .phy_sel (host_wdata[CMD_PHY_LSB +: REG_AW]),
        .reg_sel (host_wdata[CMD_REG_LSB +: REG_AW]),
        .op_code (host_wdata[CMD_OP_LSB +: 2]),
        .go      (host_wdata[CMD_GO_BIT]),
        .acc     (acc)
    );

    phy_word_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (acc.wr),
        .widx  (acc.idx),
        .wval  (wdata_q[WORD_W-1:0]),
        .words (words)
    );

    phy_status_view u_view (
        .link_up (link_up),
        .ridx    (acc.idx),
        .words   (words),
        .rval    (view_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cmd_q    <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            bad_op_q <= 1'b0;
        end else begin
            if (host_we) begin
                case (host_sel_e'(host_wsel))
                    HSEL_CTRL:  ctrl_q  <= host_wdata[CTRL_BITS-1:0];
                    HSEL_CMD:   cmd_q   <= host_wdata;
                    HSEL_WDATA: wdata_q <= host_wdata;
                    HSEL_RDATA: rdata_q <= host_wdata;
                    default:    ;
                endcase
            end
            if (acc.rd) begin
                rdata_q <= {{(HOST_W-WORD_W){1'b0}}, acc.hit ? view_val : ABSENT_WORD};
            end
            bad_op_q <= acc.bad;
        end
    end

    always_comb begin
        case (host_sel_e'(host_rsel))
            HSEL_CTRL:  host_rdata = {{(HOST_W-CTRL_BITS){1'b0}}, ctrl_q};
            HSEL_CMD:   host_rdata = cmd_q | (HOST_W'(1) << CMD_READY_BIT);
            HSEL_WDATA: host_rdata = wdata_q;
            default:    host_rdata = rdata_q;
        endcase
    end

    assign bad_op = bad_op_q;

endmodule

// File: rtl/mgmt_phy_checker.sv
module mgmt_phy_checker
    import mgmt_phy_pkg::*;
#(
    parameter int PHY_ADDR  = 7,
    parameter int CTRL_BITS = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [1:0]        host_wsel,
    input logic [HOST_W-1:0] host_wdata,
    input logic [1:0]        host_rsel,
    input logic [HOST_W-1:0] host_rdata,
    input logic [HOST_W-1:0] rdata_q,
    input logic              bad_op
);

    logic cmd_go;
    logic to_rdata;
    logic read_absent;
    logic read_r17;

    assign cmd_go      = host_we && host_wsel == 2'd1 && host_wdata[CMD_GO_BIT];
    assign to_rdata    = host_we && host_wsel == 2'd3;
    assign read_absent = cmd_go && host_wdata[CMD_OP_LSB +: 2] == 2'd2
                         && host_wdata[CMD_PHY_LSB +: REG_AW] != REG_AW'(PHY_ADDR);
    assign read_r17    = cmd_go && host_wdata[CMD_OP_LSB +: 2] == 2'd2
                         && host_wdata[CMD_PHY_LSB +: REG_AW] == REG_AW'(PHY_ADDR)
                         && host_wdata[CMD_REG_LSB +: REG_AW] == 5'd17;

    // R4: without an initiated command or a direct write, read data holds
    p_rdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!cmd_go && !to_rdata) |=> $stable(rdata_q));

    // R3: an invalid opcode never touches the read data
    p_bad_op_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> $stable(rdata_q));

    // R6: absent PHY reads all ones
    p_absent_ones_r6: assert property (@(posedge clk) disable iff (rst)
        read_absent |=> (rdata_q == 32'h0000FFFF));

    // R9: register 17 is fixed
    p_reg17_fixed_r9: assert property (@(posedge clk) disable iff (rst)
        read_r17 |=> (rdata_q == 32'h00008000));

    // R5: command word always reads ready
    p_cmd_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (host_rsel == 2'd1) |-> host_rdata[CMD_READY_BIT]);

    // R11: control word never shows bits above its width
    p_ctrl_width_r11: assert property (@(posedge clk) disable iff (rst)
        (host_rsel == 2'd0) |-> (host_rdata[HOST_W-1:CTRL_BITS] == '0));

    // R11: direct write of the read-data word stores all bits
    p_rdata_store_r11: assert property (@(posedge clk) disable iff (rst)
        to_rdata |=> (rdata_q == $past(host_wdata)));

    // R11: read-data select returns the held word
    p_rdata_view_r11: assert property (@(posedge clk) disable iff (rst)
        (host_rsel == 2'd3) |-> (host_rdata == rdata_q));

endmodule

bind mgmt_phy_top mgmt_phy_checker #(.PHY_ADDR(PHY_ADDR), .CTRL_BITS(CTRL_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_wsel  (host_wsel),
    .host_wdata (host_wdata),
    .host_rsel  (host_rsel),
    .host_rdata (host_rdata),
    .rdata_q    (rdata_q),
    .bad_op     (bad_op)
);

// File: tb/sim_mgmt_phy_top.sv
module sim_mgmt_phy_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] MY = 5'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_wsel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [1:0]  host_rsel = 2'd0;
    logic [31:0] host_rdata;
    logic        bad_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] mdl [32];
    logic        mdl_link;
    logic [31:0] cur_wdata;
    logic [31:0] exp_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_phy_top u0 (
        .clk(clk), .rst(rst), .link_up(link_up),
        .host_we(host_we), .host_wsel(host_wsel), .host_wdata(host_wdata),
        .host_rsel(host_rsel), .host_rdata(host_rdata), .bad_op(bad_op)
    );

    function automatic logic [15:0] exp_view(input logic [4:0] idx);
        logic [15:0] a;
        a = mdl[4];
        case (idx)
            5'd1:    return mdl_link ? 16'h782E : 16'h0000;
            5'd5:    return 16'h4000 | (a & 16'h01E0) | 16'h0001;
            5'd17:   return 16'h8000;
            5'd18:   return mdl_link ? {4'b0, a[8] | a[6], a[7] | a[8], 10'b0} : 16'h0000;
            default: return mdl[idx];
        endcase
    endfunction

    function automatic logic [31:0] mkcmd(input logic [4:0] phy, input logic [4:0] rg,
                                          input logic [1:0] op, input logic go);
        logic [31:0] c;
        c = '0;
        c[28:24] = phy;
        c[20:16] = rg;
        c[15:14] = op;
        c[11]    = go;
        return c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_wsel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input logic [1:0] sel, output logic [31:0] d);
        host_rsel = sel;
        #1;
        d = host_rdata;
    endtask

    task automatic set_wdata(input logic [31:0] d);
        hw(2'd2, d);
        cur_wdata = d;
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_up = v;
        mdl_link = v;
    endtask

    task automatic do_cmd(input string tag, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [1:0] op, input logic go);
        logic [31:0] got;
        logic        exp_bad;
        exp_bad = go && (op == 2'd0 || op == 2'd3);
        if (go && op == 2'd2)
            exp_rdata = (phy == MY) ? {16'h0, exp_view(rg)} : 32'h0000FFFF;
        hw(2'd1, mkcmd(phy, rg, op, go));
        if (go && op == 2'd1 && phy == MY) mdl[rg] = cur_wdata[15:0];
        check({tag, " bad_op"}, {31'b0, bad_op}, {31'b0, exp_bad});
        hr(2'd3, got);
        check({tag, " rdata"}, got, exp_rdata);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_init;
        seed_init = $urandom(32'd4242);
        for (int i = 0; i < 32; i++) mdl[i] = 16'h0;
        mdl[0] = 16'h3100; mdl[2] = 16'h0300; mdl[3] = 16'hE400; mdl[4] = 16'h01E1;
        mdl_link = 1'b1;
        cur_wdata = '0;
        exp_rdata = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state of host words (R11, R5)
        hr(2'd0, v); check("R11 ctrl reset", v, 32'h0);
        hr(2'd1, v); check("R5 cmd reset readback", v, 32'h00000080);
        hr(2'd3, v); check("R11 rdata reset", v, 32'h0);
        hr(2'd2, v); check("R11 wdata reset", v, 32'h0);
        check("R3 bad_op reset", {31'b0, bad_op}, 32'h0);

        // Reset contents and derived words (R10, R7, R8, R9)
        do_cmd("R10 reg0", MY, 5'd0, 2'd2, 1'b1);
        do_cmd("R10 reg2", MY, 5'd2, 2'd2, 1'b1);
        do_cmd("R10 reg3", MY, 5'd3, 2'd2, 1'b1);
        do_cmd("R10 reg4", MY, 5'd4, 2'd2, 1'b1);
        do_cmd("R10 reg9", MY, 5'd9, 2'd2, 1'b1);
        do_cmd("R7 reg1 up", MY, 5'd1, 2'd2, 1'b1);
        do_cmd("R8 reg5", MY, 5'd5, 2'd2, 1'b1);
        do_cmd("R9 reg17", MY, 5'd17, 2'd2, 1'b1);
        do_cmd("R9 reg18", MY, 5'd18, 2'd2, 1'b1);
        check("R1 reg18 reset value", exp_rdata, 32'h00000C00);

        // Control masking (R11)
        hw(2'd0, 32'hFFFF_FFFF);
        hr(2'd0, v); check("R11 ctrl mask", v, 32'h0000007F);
        hw(2'd0, 32'h0000_0045);
        hr(2'd0, v); check("R11 ctrl value", v, 32'h00000045);

        // Command readback, no initiate (R5, R4)
        hw(2'd1, 32'hA5A5_A000);
        hr(2'd1, v); check("R5 cmd readback", v, 32'hA5A5_A080);
        hr(2'd3, v); check("R4 no initiate", v, exp_rdata);
        do_cmd("R4 write no go", MY, 5'd9, 2'd1, 1'b0);

        // Write then read (R2)
        set_wdata(32'hBEEF_1234);
        hr(2'd2, v); check("R11 wdata store", v, 32'hBEEF_1234);
        do_cmd("R2 write reg9", MY, 5'd9, 2'd1, 1'b1);
        do_cmd("R2 read reg9", MY, 5'd9, 2'd2, 1'b1);

        // Absent address (R6)
        set_wdata(32'h0000_5555);
        do_cmd("R6 absent write", 5'd3, 5'd9, 2'd1, 1'b1);
        do_cmd("R6 reg9 kept", MY, 5'd9, 2'd2, 1'b1);
        do_cmd("R6 absent read", 5'd3, 5'd9, 2'd2, 1'b1);
        do_cmd("R6 absent read 31", 5'd31, 5'd0, 2'd2, 1'b1);

        // Invalid opcodes (R3)
        do_cmd("R3 op0", MY, 5'd9, 2'd0, 1'b1);
        do_cmd("R3 op3", MY, 5'd9, 2'd3, 1'b1);
        do_cmd("R3 recover", MY, 5'd9, 2'd2, 1'b1);

        // Advertisement drives partner/diag words (R8, R9)
        set_wdata(32'h0000_0041);
        do_cmd("R8 adv 10full", MY, 5'd4, 2'd1, 1'b1);
        do_cmd("R8 reg5 10full", MY, 5'd5, 2'd2, 1'b1);
        do_cmd("R9 reg18 10full", MY, 5'd18, 2'd2, 1'b1);
        set_wdata(32'h0000_0081);
        do_cmd("R8 adv 100half", MY, 5'd4, 2'd1, 1'b1);
        do_cmd("R8 reg5 100half", MY, 5'd5, 2'd2, 1'b1);
        do_cmd("R9 reg18 100half", MY, 5'd18, 2'd2, 1'b1);

        // Computed registers ignore stored value (R7)
        set_wdata(32'h0000_0000);
        do_cmd("R7 write reg1", MY, 5'd1, 2'd1, 1'b1);
        do_cmd("R7 reg1 still up", MY, 5'd1, 2'd2, 1'b1);

        // Link down (R7, R9)
        set_link(1'b0);
        do_cmd("R7 reg1 down", MY, 5'd1, 2'd2, 1'b1);
        do_cmd("R9 reg18 down", MY, 5'd18, 2'd2, 1'b1);
        do_cmd("R9 reg17 down", MY, 5'd17, 2'd2, 1'b1);
        set_link(1'b1);

        // Direct write of read-data word (R11)
        hw(2'd3, 32'hCAFE_F00D);
        exp_rdata = 32'hCAFE_F00D;
        hr(2'd3, v); check("R11 rdata direct", v, 32'hCAFE_F00D);

        // Random mix (R1)
        for (int it = 0; it < 400; it++) begin
            int unsigned k;
            logic [4:0] phy;
            k = $urandom % 8;
            if (k == 0) begin
                set_wdata($urandom);
            end else if (k == 1) begin
                set_link(~mdl_link);
            end else begin
                phy = ($urandom % 4 == 0) ? 5'($urandom) : MY;
                do_cmd("R1 random", phy, 5'($urandom), 2'($urandom), ($urandom % 5) != 0);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule